// File: doc/BRIEF.md
# Single-Channel Bus-Request Block Mover

This block moves a run of bytes between an I/O byte stream and system memory while the processor does other work. Software sets a starting memory address and a byte count through a three-entry register window. A write to the control entry then sets the direction and starts the copy. The engine asks for the system bus with a request line and waits for a grant. While it holds the grant, it performs one single-cycle memory access per byte on a simple synchronous bus. When the count is used up, it gives the bus back and raises a completion flag.

On the I/O side there are two valid/ready byte channels, one for each direction. A device that stalls its handshake pauses the copy without losing data. When the engine does not own the bus, its address and write-data outputs are held at zero. This stands in for the released drivers of a shared bus.

Top module: `dma_mover`

## Requirements
- R1: The register window is selected by `reg_sel`: 0 is the memory address, 1 is the byte count, 2 is control. A control write uses bit 0 as start and bit 1 as direction (1 = memory to I/O, 0 = I/O to memory). A control read returns bit 0 busy, bit 1 direction and bit 2 done, and all other bits are zero. Every entry can be read at any time on `reg_rdata`, and all of them read zero after reset.
- R2: While busy, writes to the address or count entry leave that entry unchanged.
- R3: A start with a nonzero count raises `bus_req` in the cycle after the control write. No memory access is made before `bus_gnt` is 1.
- R4: `mem_en` and `io_in_ready` are only ever 1 while both `bus_req` and `bus_gnt` are 1.
- R5: In the I/O-to-memory direction, each byte accepted on the input channel is written to memory, in that same cycle, at the current address. Each accepted byte then adds one to the address, wrapping at the address width, and takes one from the count.
- R6: In the memory-to-I/O direction, each byte is read at the current address and presented on the output channel. `io_out_valid` and `io_out_data` stay steady until `io_out_ready` is 1. Each accepted byte adds one to the address and takes one from the count.
- R7: In the cycle after the last byte moves, `bus_req` is 0. Done becomes 1 and busy becomes 0 once `bus_gnt` has been seen at 0.
- R8: Done stays at 1 until the next control write while idle, and that write clears it.
- R9: A start with a count of zero sets done in the next cycle and never raises `bus_req`.
- R10: A control write while busy is ignored: it does not change the direction and does not restart the copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register window select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for `reg_sel` |
| done | output | 1 | Completion flag |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address, zero when not accessing |
| mem_wdata | output | 8 | Memory write data, zero when not writing |
| mem_rdata | input | 8 | Memory read data, one cycle after a read |
| io_in_valid | input | 1 | Input byte valid |
| io_in_data | input | 8 | Input byte |
| io_in_ready | output | 1 | Input byte accepted |
| io_out_valid | output | 1 | Output byte valid |
| io_out_data | output | 8 | Output byte |
| io_out_ready | input | 1 | Output byte taken |

## Verification
The bench builds the block with its default widths: a 16-bit address, a 16-bit count and a 16-bit register window. With these widths, a copy that starts at address 0xFFFF is within reach, so wrap-around of the address register is exercised. Short counts of 0 to 5 bytes cover the zero-count shortcut, the final-byte release and the stalls in both directions within a few hundred cycles. The processor model grants the bus one cycle after the request and withdraws it one cycle after the release. This makes the release phase visible before done is raised.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_PULL,
    ST_RD,
    ST_LAT,
    ST_PUSH,
    ST_DRAIN
  } mover_state_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CW_GO  = 0;
  localparam int CW_DIR = 1;

  localparam int CR_BUSY = 0;
  localparam int CR_DIR  = 1;
  localparam int CR_DONE = 2;

endpackage

// File: rtl/dma_mover_regs.sv
module dma_mover_regs
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              step,
  input  logic              finish,
  output logic              start_go,
  output logic              start_zero,
  output logic              cnt_last,
  output logic              dir_q,
  output logic              done_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  count_q
);

  function automatic logic [ADDR_W-1:0] addr_after(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] count_after(input logic [CNT_W-1:0] c);
    return c - 1'b1;
  endfunction

  function automatic logic is_final(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  logic idle_ctrl_wr;
  logic addr_wr_ok;
  logic cnt_wr_ok;

  assign idle_ctrl_wr = reg_wr && (reg_sel == SEL_CTRL) && !busy;
  assign addr_wr_ok   = reg_wr && (reg_sel == SEL_ADDR) && !busy;
  assign cnt_wr_ok    = reg_wr && (reg_sel == SEL_CNT)  && !busy;
  assign start_go     = idle_ctrl_wr && reg_wdata[CW_GO] && (count_q != '0);
  assign start_zero   = idle_ctrl_wr && reg_wdata[CW_GO] && (count_q == '0);
  assign cnt_last     = is_final(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (addr_wr_ok)      addr_q <= reg_wdata[ADDR_W-1:0];
      else if (step)       addr_q <= addr_after(addr_q);

      if (cnt_wr_ok)       count_q <= reg_wdata[CNT_W-1:0];
      else if (step)       count_q <= count_after(count_q);

      if (idle_ctrl_wr)    dir_q <= reg_wdata[CW_DIR];

      if (finish || start_zero) done_q <= 1'b1;
      else if (idle_ctrl_wr)    done_q <= 1'b0;
    end
  end

  logic [REG_W-1:0] ctrl_view;
  always_comb begin
    ctrl_view          = '0;
    ctrl_view[CR_BUSY] = busy;
    ctrl_view[CR_DIR]  = dir_q;
    ctrl_view[CR_DONE] = done_q;
  end

  always_comb begin
    unique case (reg_sel)
      SEL_ADDR: reg_rdata = REG_W'(addr_q);
      SEL_CNT:  reg_rdata = REG_W'(count_q);
      SEL_CTRL: reg_rdata = ctrl_view;
      default:  reg_rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;

endmodule

// File: rtl/dma_mover_seq.sv
module dma_mover_seq
  import dma_mover_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_go,
  input  logic dir,
  input  logic cnt_last,
  input  logic bus_gnt,
  input  logic io_in_valid,
  input  logic io_out_ready,
  output logic busy,
  output logic bus_req,
  output logic step,
  output logic finish,
  output logic mem_en,
  output logic mem_we,
  output logic rd_latch,
  output logic io_in_ready,
  output logic io_out_valid
);

  mover_state_e st, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt          = st;
    step         = 1'b0;
    finish       = 1'b0;
    mem_en       = 1'b0;
    mem_we       = 1'b0;
    rd_latch     = 1'b0;
    io_in_ready  = 1'b0;
    io_out_valid = 1'b0;
    unique case (st)
      ST_IDLE:  if (start_go) nxt = ST_REQ;
      ST_REQ:   if (bus_gnt) nxt = dir ? ST_RD : ST_PULL;
      ST_PULL: begin
        io_in_ready = bus_gnt;
        if (bus_gnt && io_in_valid) begin
          step   = 1'b1;
          mem_en = 1'b1;
          mem_we = 1'b1;
          if (cnt_last) nxt = ST_DRAIN;
        end
      end
      ST_RD: begin
        if (bus_gnt) begin
          mem_en = 1'b1;
          nxt    = ST_LAT;
        end
      end
      ST_LAT: begin
        rd_latch = 1'b1;
        nxt      = ST_PUSH;
      end
      ST_PUSH: begin
        io_out_valid = 1'b1;
        if (io_out_ready) begin
          step = 1'b1;
          nxt  = cnt_last ? ST_DRAIN : ST_RD;
        end
      end
      ST_DRAIN: begin
        if (!bus_gnt) begin
          finish = 1'b1;
          nxt    = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy    = (st != ST_IDLE);
  assign bus_req = (st != ST_IDLE) && (st != ST_DRAIN);

endmodule

// File: rtl/dma_mover_port.sv
module dma_mover_port #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_en,
  input  logic              mem_we,
  input  logic              rd_latch,
  input  logic              io_out_valid,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [7:0]        io_in_data,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [7:0]        io_out_data
);

  logic [7:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (rd_latch) hold_q <= mem_rdata;
  end

  assign mem_addr    = mem_en ? addr_q : '0;
  assign mem_wdata   = mem_we ? io_in_data : '0;
  assign io_out_data = io_out_valid ? hold_q : '0;

endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_mover_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              io_in_valid,
  input  logic [7:0]        io_in_data,
  output logic              io_in_ready,
  output logic              io_out_valid,
  output logic [7:0]        io_out_data,
  input  logic              io_out_ready
);

  logic              busy;
  logic              step;
  logic              finish;
  logic              start_go;
  logic              start_zero;
  logic              cnt_last;
  logic              dir_q;
  logic              rd_latch;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  count_q;

  dma_mover_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .step       (step),
    .finish     (finish),
    .start_go   (start_go),
    .start_zero (start_zero),
    .cnt_last   (cnt_last),
    .dir_q      (dir_q),
    .done_q     (done),
    .addr_q     (addr_q),
    .count_q    (count_q)
  );

  dma_mover_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_go     (start_go),
    .dir          (dir_q),
    .cnt_last     (cnt_last),
    .bus_gnt      (bus_gnt),
    .io_in_valid  (io_in_valid),
    .io_out_ready (io_out_ready),
    .busy         (busy),
    .bus_req      (bus_req),
    .step         (step),
    .finish       (finish),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .rd_latch     (rd_latch),
    .io_in_ready  (io_in_ready),
    .io_out_valid (io_out_valid)
  );

  dma_mover_port #(.ADDR_W(ADDR_W)) u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_en       (mem_en),
    .mem_we       (mem_we),
    .rd_latch     (rd_latch),
    .io_out_valid (io_out_valid),
    .addr_q       (addr_q),
    .io_in_data   (io_in_data),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .io_out_data  (io_out_data)
  );

endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              mem_en,
  input logic              io_in_ready,
  input logic              io_out_valid,
  input logic [7:0]        io_out_data,
  input logic              io_out_ready,
  input logic              done,
  input logic              busy,
  input logic              step,
  input logic              start_go,
  input logic              start_zero,
  input logic              cnt_last,
  input logic              dir_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [CNT_W-1:0]  count_q
);

  p_go_requests_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> bus_req);

  p_mem_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (bus_req && bus_gnt));

  p_in_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_in_ready |-> (bus_req && bus_gnt));

  p_step_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)) &&
             (count_q == CNT_W'($past(count_q) - 1'b1)));

  p_out_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_out_valid && !io_out_ready) |=> (io_out_valid && $stable(io_out_data)));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_last) |=> !bus_req);

  p_done_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(reg_wr && reg_sel == 2'd2)) |=> done);

  p_zero_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_zero |=> (done && !bus_req));

  p_addr_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_sel == 2'd0 && !step) |=> $stable(addr_q));

  p_cnt_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_sel == 2'd1 && !step) |=> $stable(count_q));

  p_dir_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_sel == 2'd2) |=> $stable(dir_q));

endmodule

bind dma_mover dma_mover_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_sel      (reg_sel),
  .reg_wr       (reg_wr),
  .bus_req      (bus_req),
  .bus_gnt      (bus_gnt),
  .mem_en       (mem_en),
  .io_in_ready  (io_in_ready),
  .io_out_valid (io_out_valid),
  .io_out_data  (io_out_data),
  .io_out_ready (io_out_ready),
  .done         (done),
  .busy         (busy),
  .step         (step),
  .start_go     (start_go),
  .start_zero   (start_zero),
  .cnt_last     (cnt_last),
  .dir_q        (dir_q),
  .addr_q       (addr_q),
  .count_q      (count_q)
);

// File: tb/dma_mover_tb.sv
`timescale 1ns/1ps
module dma_mover_tb;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;
  localparam int REG_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        reg_sel = '0;
  logic              reg_wr = 1'b0;
  logic [REG_W-1:0]  reg_wdata = '0;
  logic [REG_W-1:0]  reg_rdata;
  logic              done;
  logic              bus_req;
  logic              bus_gnt;
  logic              mem_en;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic [7:0]        mem_rdata;
  logic              io_in_valid = 1'b0;
  logic [7:0]        io_in_data = '0;
  logic              io_in_ready;
  logic              io_out_valid;
  logic [7:0]        io_out_data;
  logic              io_out_ready = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dma_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_in_valid(io_in_valid), .io_in_data(io_in_data), .io_in_ready(io_in_ready),
    .io_out_valid(io_out_valid), .io_out_data(io_out_data), .io_out_ready(io_out_ready)
  );

  // processor model: grant follows request by one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req;
  end

  function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ 8'hC3 ^ a[15:8];
  endfunction

  // memory model: one-cycle synchronous read of a computed pattern
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mem_rdata <= '0;
    else if (mem_en && !mem_we)  mem_rdata <= pat(mem_addr);
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [ADDR_W-1:0] q_waddr[$];
  logic [7:0]        q_wdata[$];
  logic [7:0]        q_out[$];
  bit                rel_pending = 0;
  bit                stall_seen = 0;
  logic [7:0]        stall_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rel_pending) begin
        check(bus_req == 1'b0, "R7 request dropped after last byte", 32'(bus_req), 0);
        rel_pending = 0;
      end
      if (stall_seen) begin
        check(io_out_valid && io_out_data == stall_data, "R6 output held while stalled",
              32'(io_out_data), 32'(stall_data));
        stall_seen = 0;
      end
      if (mem_en) check(bus_gnt && bus_req, "R4 access only while owning bus", 32'(bus_gnt), 1);
      if (io_in_ready) check(bus_gnt && bus_req, "R4 input ready only while owning bus", 32'(bus_gnt), 1);
      if (mem_en && mem_we) begin
        if (q_waddr.size() == 0) check(0, "R5 unexpected memory write", 32'(mem_addr), 0);
        else begin
          logic [ADDR_W-1:0] ea;
          logic [7:0] ed;
          ea = q_waddr.pop_front();
          ed = q_wdata.pop_front();
          check(mem_addr == ea, "R5 write address", 32'(mem_addr), 32'(ea));
          check(mem_wdata == ed, "R5 write data", 32'(mem_wdata), 32'(ed));
          if (q_waddr.size() == 0) rel_pending = 1;
        end
      end
      if (io_out_valid && io_out_ready) begin
        if (q_out.size() == 0) check(0, "R6 unexpected output byte", 32'(io_out_data), 0);
        else begin
          logic [7:0] eo;
          eo = q_out.pop_front();
          check(io_out_data == eo, "R6 output byte", 32'(io_out_data), 32'(eo));
          if (q_out.size() == 0) rel_pending = 1;
        end
      end else if (io_out_valid && !io_out_ready) begin
        stall_seen = 1;
        stall_data = io_out_data;
      end
    end
  end

  task automatic wreg(input logic [1:0] sel, input logic [REG_W-1:0] v);
    @(posedge clk); #1;
    reg_sel = sel; reg_wdata = v; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] sel, output logic [REG_W-1:0] v);
    @(posedge clk); #1;
    reg_sel = sel;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_done();
    logic [REG_W-1:0] c;
    int tries;
    tries = 0;
    c = '0;
    while (!c[2] && tries < 500) begin
      rreg(2'd2, c);
      tries++;
    end
    check(c[2] == 1'b1, "R7 done reached", 32'(c), 32'h4);
  endtask

  task automatic feed(input int n, input int gap, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      io_in_valid = 1'b0;
      repeat (gap) begin @(posedge clk); #1; end
      io_in_valid = 1'b1;
      io_in_data  = seed + 8'(i);
      @(negedge clk);
      while (!io_in_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    io_in_valid = 1'b0;
  endtask

  task automatic sink(input int n, input bit stall);
    int got;
    int k;
    got = 0;
    k = 0;
    while (got < n) begin
      io_out_ready = !stall || (k % 3 == 2);
      k++;
      @(negedge clk);
      if (io_out_valid && io_out_ready) got++;
      @(posedge clk); #1;
    end
    io_out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [REG_W-1:0] v;
    int reqs;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rreg(2'd0, v); check(v == 0, "R1 address after reset", 32'(v), 0);
    rreg(2'd1, v); check(v == 0, "R1 count after reset", 32'(v), 0);
    rreg(2'd2, v); check(v == 0, "R1 control after reset", 32'(v), 0);
    check(bus_req == 0, "R1 no request after reset", 32'(bus_req), 0);

    // R1 readback, R3, R5: 4 bytes into memory with uneven gaps
    wreg(2'd0, 16'h0010);
    wreg(2'd1, 16'd4);
    rreg(2'd0, v); check(v == 16'h0010, "R1 address readback", 32'(v), 32'h10);
    rreg(2'd1, v); check(v == 16'd4, "R1 count readback", 32'(v), 4);
    for (int i = 0; i < 4; i++) begin
      q_waddr.push_back(16'h0010 + 16'(i));
      q_wdata.push_back(8'h30 + 8'(i));
    end
    wreg(2'd2, 16'h0001);
    @(negedge clk);
    check(bus_req == 1'b1, "R3 request after start", 32'(bus_req), 1);
    check(mem_en == 1'b0, "R3 no access before grant", 32'(mem_en), 0);
    @(posedge clk); #1;
    feed(4, 2, 8'h30);
    wait_done();
    rreg(2'd2, v); check(v == 16'h0004, "R7 control shows done idle", 32'(v), 4);
    rreg(2'd0, v); check(v == 16'h0014, "R5 address advanced", 32'(v), 32'h14);
    rreg(2'd1, v); check(v == 0, "R5 count exhausted", 32'(v), 0);

    // R8 done held, then cleared by control write
    repeat (5) @(posedge clk);
    rreg(2'd2, v); check(v[2] == 1'b1, "R8 done held", 32'(v), 4);
    wreg(2'd2, 16'h0000);
    rreg(2'd2, v); check(v == 0, "R8 done cleared", 32'(v), 0);

    // R9 zero count start
    wreg(2'd2, 16'h0001);
    rreg(2'd2, v); check(v == 16'h0004, "R9 zero count done at once", 32'(v), 4);
    reqs = 0;
    repeat (8) begin @(negedge clk); if (bus_req) reqs++; end
    check(reqs == 0, "R9 no request for zero count", 32'(reqs), 0);
    wreg(2'd2, 16'h0000);

    // R6 memory to I/O with stalled sink
    wreg(2'd0, 16'h0040);
    wreg(2'd1, 16'd5);
    for (int i = 0; i < 5; i++) q_out.push_back(pat(16'h0040 + 16'(i)));
    wreg(2'd2, 16'h0003);
    sink(5, 1'b1);
    wait_done();
    rreg(2'd2, v); check(v == 16'h0006, "R6 control done with direction", 32'(v), 6);
    rreg(2'd0, v); check(v == 16'h0045, "R6 address advanced", 32'(v), 32'h45);
    wreg(2'd2, 16'h0000);

    // R5 address wrap
    wreg(2'd0, 16'hFFFF);
    wreg(2'd1, 16'd2);
    q_waddr.push_back(16'hFFFF); q_wdata.push_back(8'h70);
    q_waddr.push_back(16'h0000); q_wdata.push_back(8'h71);
    wreg(2'd2, 16'h0001);
    feed(2, 0, 8'h70);
    wait_done();
    rreg(2'd0, v); check(v == 16'h0001, "R5 address wrapped", 32'(v), 1);
    wreg(2'd2, 16'h0000);

    // R2 and R10: writes while busy are ignored
    wreg(2'd0, 16'h0080);
    wreg(2'd1, 16'd3);
    for (int i = 0; i < 3; i++) begin
      q_waddr.push_back(16'h0080 + 16'(i));
      q_wdata.push_back(8'h90 + 8'(i));
    end
    wreg(2'd2, 16'h0001);
    fork
      feed(3, 8, 8'h90);
      begin
        wreg(2'd0, 16'h0055);
        wreg(2'd1, 16'd9);
        wreg(2'd2, 16'h0003);
        rreg(2'd2, v);
        check(v[1:0] == 2'b01, "R10 direction kept while busy", 32'(v), 1);
      end
    join
    wait_done();
    rreg(2'd0, v); check(v == 16'h0083, "R2 address write ignored", 32'(v), 32'h83);
    rreg(2'd1, v); check(v == 0, "R2 count write ignored", 32'(v), 0);
    wreg(2'd2, 16'h0000);

    repeat (3) @(posedge clk);
    check(q_waddr.size() == 0, "R5 all writes seen", 32'(q_waddr.size()), 0);
    check(q_out.size() == 0, "R6 all output bytes seen", 32'(q_out.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule